// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for each beat of a memory burst. When a read or write command is accepted, the controller pulses a start strobe together with the starting column and the current mode settings (burst length code and burst type). From the next cycle on, the generator presents one column address per clock, marked by a beat-valid flag, until the burst ends.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap their low address bits inside an aligned block, in either sequential or interleaved order. A full-page burst walks the whole 512-column page and wraps around it with no natural end. It finishes only when a terminate strobe arrives.

A start strobe on any cycle, even in the middle of a burst, discards the burst in progress and begins a new one. A last-beat flag marks the final beat of a fixed-length burst so that the controller can schedule the next command.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is sampled low, and in the cycle after it, `beat_valid` and `last_beat` are 0.
- R2: In the cycle after `start` is sampled high, `beat_valid` is 1 and `col` equals the sampled `start_col`. This is beat 0.
- R3: `len_code` is sampled with `start`. When bit 2 is 0, bits 1:0 select 1, 2, 4 or 8 beats (codes 0 to 3). When bit 2 is 1, the burst is full page, whatever bits 1:0 hold.
- R4: Sequential fixed burst (`interleave`=0), beat k of length BL: `col` keeps the bits of `start_col` above log2(BL), and its low log2(BL) bits equal (low bits of `start_col` + k) mod BL.
- R5: Interleaved fixed burst (`interleave`=1), beat k: the upper bits are kept, and the low log2(BL) bits equal (low bits of `start_col`) XOR k.
- R6: Full-page burst, beat k: `col` = (`start_col` + k) mod 512. The burst type has no effect, and beats continue past 512 until a terminate.
- R7: `last_beat` is 1 exactly on beat BL-1 of a fixed-length burst. It is never 1 in a full-page burst.
- R8: In the cycle after a last beat, `beat_valid` is 0, unless `start` was sampled high on that beat.
- R9: `term` sampled high during a valid beat ends the burst: `beat_valid` is 0 the next cycle. `term` while idle has no effect. When `start` and `term` are high together, `start` wins.
- R10: `start` during a burst restarts it at the new column, with the newly sampled length and type.
- R11: Changes on `len_code` or `interleave` between start strobes do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| len_code | input | 3 | Burst length code, sampled with start |
| interleave | input | 1 | Burst type: 1 = interleaved, 0 = sequential |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 9 | Starting column address |
| term | input | 1 | Burst terminate strobe |
| col | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output is due one clock after the edge that samples the strobe behind it. A start shows up as beat 0, a terminate or a last beat shows up as idle, and each further edge advances the beat by one. The bench drives inputs on the falling edge and advances its own reference model on the rising edge. It compares `beat_valid`, `last_beat` and `col` at the next falling edge, so every comparison falls exactly one register stage after its stimulus. Directed sequences cover page wrap, terminate while idle, start and terminate together, and mode changes mid-burst. Several thousand seeded random cycles then mix all of these.

// File: rtl/colgen_pkg.sv
// Shared types for the burst column generator.
// Assumes: the length field holds log2 of a fixed burst length.
package colgen_pkg;
    typedef struct packed {
        logic       full;     // full-page burst
        logic [1:0] log_len;  // log2 of fixed burst length
        logic       ilv;      // interleaved order
    } burst_mode_t;
endpackage

// File: rtl/colgen_ctrl.sv
// Burst sequencer: holds the burst state, counts beats and flags the last one.
// Assumes: start outranks term; full-page bursts run until terminated.
module colgen_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  burst_mode_t      mode_in,
    input  logic [COL_W-1:0] start_col,
    output logic             valid,
    output logic             last,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base,
    output burst_mode_t      mode
);
    localparam logic [COL_W-1:0] ONE = 1;

    logic [COL_W-1:0] len_mask;

    // Beat mask of the latched fixed length (BL-1).
    always_comb len_mask = (ONE << mode.log_len) - ONE;

    // Last beat of a fixed-length burst.
    always_comb last = valid && !mode.full && (cnt == len_mask);

    // Burst state: load on start, step per beat, stop on last beat or term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            cnt   <= '0;
            base  <= '0;
            mode  <= '0;
        end else if (start) begin
            valid <= 1'b1;
            cnt   <= '0;
            base  <= start_col;
            mode  <= mode_in;
        end else if (valid) begin
            if (term || last) valid <= 1'b0;
            else              cnt   <= cnt + ONE;
        end
    end

    // R7: full page never raises last.
    p_no_last_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode.full) |-> !last);
    // R8: idle after the last beat unless restarted.
    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !valid);
    // R9: terminate ends the burst.
    p_term_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && term && !start) |=> !valid);
    // R4: beats advance by one per clock.
    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start && !term && !last) |=> (valid && cnt == $past(cnt) + ONE));
endmodule

// File: rtl/colgen_addr.sv
// Address former: merges the start column with the beat count per burst order.
// Assumes: the count is below BL for fixed bursts; full page ignores the order.
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  burst_mode_t      mode,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] col
);
    localparam logic [COL_W-1:0] ONE = 1;

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] low;

    // Bits that move within the burst: BL-1 for fixed, all bits for full page.
    always_comb wrap_mask = mode.full ? '1 : ((ONE << mode.log_len) - ONE);

    // Sequential adds, interleaved XORs; full page always adds.
    always_comb low = (mode.ilv && !mode.full) ? (base ^ cnt) : (base + cnt);

    // Keep the block bits of the start column, replace the wrapping bits.
    always_comb col = (base & ~wrap_mask) | (low & wrap_mask);
endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column generator: decodes the length code and joins
// the sequencer to the address former.
// Assumes: len_code bit 2 selects full page; inputs sampled on the rising edge.
module burst_col_gen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             term,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             last_beat
);
    burst_mode_t      mode_in;
    burst_mode_t      mode_q;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;

    // Pack the mode inputs into the shared struct.
    always_comb mode_in = '{full: len_code[2], log_len: len_code[1:0], ilv: interleave};

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .term(term),
        .mode_in(mode_in), .start_col(start_col),
        .valid(beat_valid), .last(last_beat), .cnt(cnt), .base(base), .mode(mode_q)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .mode(mode_q), .base(base), .cnt(cnt), .col(col)
    );

    // R2: a start yields beat 0 at the start column.
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && col == $past(start_col)));
    // R1: reset clears the outputs.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!beat_valid && !last_beat));
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic       term = 1'b0;
    logic [8:0] col;
    logic       beat_valid, last_beat;

    int checks = 0, errors = 0;

    // Reference model state.
    int m_valid = 0, m_cnt = 0, m_s = 0, m_log = 0, m_full = 0, m_ilv = 0;

    burst_col_gen u0 (.clk(clk), .rst_n(rst_n), .len_code(len_code),
        .interleave(interleave), .start(start), .start_col(start_col),
        .term(term), .col(col), .beat_valid(beat_valid), .last_beat(last_beat));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_col(int s, int k, int lg, int full, int ilv);
        int bl, lo, blk;
        if (full != 0) return (s + k) % 512;
        bl  = 1 << lg;
        lo  = s % bl;
        blk = s - lo;
        if (ilv != 0) return blk + (lo ^ k);
        return blk + ((lo + k) % bl);
    endfunction

    function automatic int exp_last();
        return (m_valid != 0 && m_full == 0 && m_cnt == (1 << m_log) - 1) ? 1 : 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, int'(beat_valid), m_valid);
        chk((m_full != 0) ? "R7" : tag, int'(last_beat), exp_last());
        if (m_valid != 0)
            chk(tag, int'(col), exp_col(m_s, m_cnt, m_log, m_full, m_ilv));
    endtask

    // Model update on a rising edge with the inputs currently driven.
    task automatic model_edge();
        int lst;
        lst = exp_last();
        if (!rst_n) m_valid = 0;
        else if (start) begin
            m_valid = 1; m_cnt = 0; m_s = int'(start_col);
            m_log = int'(len_code[1:0]); m_full = int'(len_code[2]); m_ilv = int'(interleave);
        end else if (m_valid != 0) begin
            if (term || lst != 0) m_valid = 0;
            else m_cnt = (m_cnt + 1) % 512;
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, check at the next falling edge.
    task automatic step(bit st, int sc, bit tm, int lc, bit il, string tag);
        start = st; start_col = 9'(sc); term = tm; len_code = 3'(lc); interleave = il;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        @(negedge clk);
        step(0, 0, 0, 0, 0, "R1");
        step(1, 9'h1F5, 0, 3, 0, "R1");   // start under reset is ignored
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1");
        // R2/R4: sequential length 8 from 0x1F5.
        step(1, 9'h1F5, 0, 3, 0, "R2");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 3, 0, (i == 7) ? "R8" : "R4");
        // R5: interleaved length 4 from 0x0A6.
        step(1, 9'h0A6, 0, 2, 1, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 2, 1, "R5");
        // R3: lengths 1 and 2.
        step(1, 9'h033, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R3");
        step(1, 9'h033, 0, 1, 1, "R3");
        for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 1, "R3");
        // R6: full page wraps past 511 and keeps going; R3: bits 1:0 ignored.
        step(1, 9'h1FC, 0, 6, 1, "R6");
        for (int i = 0; i < 520; i++) step(0, 0, 0, 0, 0, "R6");
        // R9: terminate ends it.
        step(0, 0, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R9");        // term while idle
        step(0, 0, 0, 0, 0, "R9");
        // R11: mode changes mid-burst ignored.
        step(1, 9'h010, 0, 3, 0, "R11");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 4 + (i % 3), ~i[0], "R11");
        // R10: restart mid-burst; start with term wins (R9).
        step(1, 9'h100, 0, 3, 1, "R10");
        step(0, 0, 0, 3, 1, "R10");
        step(1, 9'h0FF, 1, 2, 0, "R10");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 2, 0, "R10");
        step(1, 9'h045, 0, 1, 0, "R8");   // start on last beat keeps going
        step(1, 9'h1FF, 0, 7, 0, "R8");
        step(0, 0, 0, 0, 0, "R6");
        // Seeded random mix.
        for (int i = 0; i < 4000; i++) begin
            bit st, tm;
            st = ($urandom % 8) == 0;
            tm = ($urandom % 16) == 0;
            step(st, int'($urandom % 512), tm, int'($urandom % 8), 1'($urandom % 2),
                 (m_full != 0) ? "R6" : ((m_ilv != 0) ? "R5" : "R4"));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule